// File: doc/BRIEF.md
# Smart-Card Character Serial Framer

This block moves single characters over the one-wire asynchronous line used by smart cards and subscriber identity cards. Its transmit half accepts a byte on a valid/ready handshake and sends one framed character: a low start bit, eight data bits, a parity bit, then a run of high guard bit-times. Its receive half watches the line, checks that a start edge is real at mid-bit, samples every following bit at its centre, rebuilds the byte and holds it for the consumer until acknowledged. A parity error flag and an overrun flag travel with the held byte.

One select input picks the bit convention, and that choice changes three things together on both halves. With the direct convention, bits go out least significant first, unchanged, with even parity. With the inverse convention, bits go out most significant first, complemented, with odd parity. The receiver undoes the same mapping, so the consumer always sees the byte the sender started with. The bit period is a run-time divider value in clock cycles.

Top module: `sc_char_framer`

## Requirements
- R1: After reset the line output `txd` is high, `tx_ready` is 1, and `rx_valid`, `rx_parity_err` and `rx_overrun` are 0.
- R2: With `inv_conv`=0 the eight data bits leave on the line as bit 0 first and bit 7 last, uncomplemented. The parity bit then makes the count of ones over those eight line bits plus itself even.
- R3: With `inv_conv`=1 the line carries the complement of bit 7 first and the complement of bit 0 last. The parity bit then makes the count of ones over those eight line bits plus itself odd.
- R4: A character takes exactly (10+`GUARD_BITS`) bit-times of `bit_div` clocks each: start bit low, eight data bits, the parity bit, then `GUARD_BITS` high bit-times. `tx_ready` is low throughout and returns high on the clock after the last guard bit-time.
- R5: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1, and `txd` is low from the following cycle.
- R6: A character received in either convention sets `rx_valid` with `rx_data` equal to the original byte.
- R7: `rx_parity_err` is 1 with the delivered byte when the received parity bit does not match the selected sense, and 0 when it matches. The byte is delivered in both cases.
- R8: A low pulse on the line that ends before half a bit-time has passed does not start a character. The receiver stays ready for the next real start bit.
- R9: `rx_valid`, `rx_data` and `rx_parity_err` hold until a cycle with `rx_ack`=1. After that cycle `rx_valid` is 0.
- R10: If a character completes while `rx_valid` is 1 and `rx_ack` is 0, the new byte replaces the held one and `rx_overrun` becomes 1. An acknowledge clears `rx_overrun`.
- R11: `inv_conv` changes only while the transmitter is idle and the receiver waits for a start bit. The next character after a change uses the new convention throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_conv | input | 1 | Convention select: 0 direct, 1 inverse |
| bit_div | input | DIV_W | Clocks per bit-time, at least 4 |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial line output, idles high |
| rxd | input | 1 | Serial line input |
| rx_data | output | 8 | Received byte in true polarity |
| rx_valid | output | 1 | A received byte is held |
| rx_ack | input | 1 | Consumer takes the held byte |
| rx_parity_err | output | 1 | Held byte arrived with wrong parity |
| rx_overrun | output | 1 | A byte was lost before acknowledge |

## Verification
The bench builds the block with `DIV_W`=8, `GUARD_BITS`=2 and a bit period of 8 clocks. Each 12-bit character then lasts under a hundred cycles. That keeps a loopback of all 256 byte values in both conventions well within the run. Every line bit of every character is compared with a bit computed by counting in the bench, and so is the recovered byte. The short period also lets the bench hand-drive frames with wrong parity and a sub-half-bit glitch, and hold bytes unacknowledged long enough to force an overrun.

// File: rtl/sc_framer_pkg.sv
package sc_framer_pkg;

  localparam int CHAR_W = 8;

  typedef logic [CHAR_W-1:0] char_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // Element i of the result is the i-th data bit placed on the line.
  function automatic char_t to_line_order(char_t d, logic inv);
    char_t r;
    for (int i = 0; i < CHAR_W; i++) begin
      r[i] = inv ? ~d[CHAR_W-1-i] : d[i];
    end
    return r;
  endfunction

  // The mapping is its own inverse, so the receiver reuses it.
  function automatic char_t from_line_order(char_t line, logic inv);
    return to_line_order(line, inv);
  endfunction

  // Even sense for direct, odd sense for inverse.
  function automatic logic parity_for(char_t line, logic inv);
    return (^line) ^ inv;
  endfunction

  function automatic logic parity_bad(char_t line, logic p, logic inv);
    return ((^line) ^ p) != inv;
  endfunction

endpackage

// File: rtl/sc_tx.sv
module sc_tx
  import sc_framer_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int GUARD_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic [DIV_W-1:0] bit_div,
  input  char_t            data,
  input  logic             valid,
  output logic             ready,
  output logic             txd,
  output logic             start_o,
  output logic             busy_o
);

  localparam int FRAME_W = CHAR_W + 2 + GUARD_BITS;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frm_q;
  logic [DIV_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;

  char_t line_w;
  logic  par_w;
  logic  bit_end_w;
  logic  last_w;

  always_comb begin
    line_w    = to_line_order(data, inv);
    par_w     = parity_for(line_w, inv);
    start_o   = valid && !busy_q;
    bit_end_w = busy_q && (cnt_q == bit_div - 1'b1);
    last_w    = (idx_q == IDX_W'(FRAME_W-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      frm_q  <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      frm_q  <= {{GUARD_BITS{1'b1}}, par_w, line_w, 1'b0};
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (bit_end_w) begin
        cnt_q <= '0;
        frm_q <= {1'b1, frm_q[FRAME_W-1:1]};
        if (last_w) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready  = !busy_q;
  assign txd    = busy_q ? frm_q[0] : 1'b1;
  assign busy_o = busy_q;

endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_framer_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic [DIV_W-1:0] bit_div,
  input  logic             rxd,
  output logic             done_o,
  output char_t            data_o,
  output logic             perr_o,
  output logic             idle_o
);

  localparam int IDX_W = $clog2(CHAR_W);

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  char_t            line_q;
  logic             done_q;
  char_t            data_q;
  logic             perr_q;

  logic [DIV_W-1:0] half_w;
  logic             bit_end_w;
  logic             half_hit_w;

  always_comb begin
    rx_s       = sync_q[1];
    half_w     = bit_div >> 1;
    bit_end_w  = (cnt_q == bit_div - 1'b1);
    half_hit_w = (cnt_q == half_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      line_q <= '0;
      done_q <= 1'b0;
      data_q <= '0;
      perr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) begin
            st_q <= RX_START;
          end
        end
        RX_START: begin
          if (half_hit_w) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end_w) begin
            cnt_q         <= '0;
            line_q[idx_q] <= rx_s;
            if (idx_q == IDX_W'(CHAR_W-1)) begin
              st_q <= RX_PAR;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_end_w) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            data_q <= from_line_order(line_q, inv);
            perr_q <= parity_bad(line_q, rx_s, inv);
            st_q   <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end_w) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= RX_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign idle_o = (st_q == RX_IDLE);

endmodule

// File: rtl/sc_rx_hold.sv
module sc_rx_hold
  import sc_framer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done,
  input  char_t data_in,
  input  logic  perr_in,
  input  logic  ack,
  output char_t data_o,
  output logic  valid_o,
  output logic  perr_o,
  output logic  ovr_o
);

  logic lost_w;

  always_comb begin
    lost_w = done && valid_o && !ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (done) begin
      data_o  <= data_in;
      perr_o  <= perr_in;
      valid_o <= 1'b1;
      ovr_o   <= lost_w ? 1'b1 : (ack ? 1'b0 : ovr_o);
    end else if (ack) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_char_framer.sv
module sc_char_framer
  import sc_framer_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int GUARD_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_conv,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ack,
  output logic             rx_parity_err,
  output logic             rx_overrun
);

  // Named internal events, observed by the bound checker.
  logic  tx_start;
  logic  tx_busy;
  logic  rx_done;
  logic  rx_idle;
  char_t rx_raw_data;
  logic  rx_raw_perr;

  sc_tx #(
    .DIV_W     (DIV_W),
    .GUARD_BITS(GUARD_BITS)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .inv    (inv_conv),
    .bit_div(bit_div),
    .data   (tx_data),
    .valid  (tx_valid),
    .ready  (tx_ready),
    .txd    (txd),
    .start_o(tx_start),
    .busy_o (tx_busy)
  );

  sc_rx #(
    .DIV_W(DIV_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .inv    (inv_conv),
    .bit_div(bit_div),
    .rxd    (rxd),
    .done_o (rx_done),
    .data_o (rx_raw_data),
    .perr_o (rx_raw_perr),
    .idle_o (rx_idle)
  );

  sc_rx_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (rx_done),
    .data_in(rx_raw_data),
    .perr_in(rx_raw_perr),
    .ack    (rx_ack),
    .data_o (rx_data),
    .valid_o(rx_valid),
    .perr_o (rx_parity_err),
    .ovr_o  (rx_overrun)
  );

endmodule

// File: rtl/sc_char_framer_chk.sv
module sc_char_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inv_conv,
  input logic       tx_ready,
  input logic       txd,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ack,
  input logic       rx_overrun,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       rx_done,
  input logic       rx_idle
);

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd); // R5

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_ready); // R4

  AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid); // R6

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack && !rx_done) |=> (rx_valid && $stable(rx_data))); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_done) |=> (!rx_valid && !rx_overrun)); // R10

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_valid && !rx_ack) |=> rx_overrun); // R10

  AST_CONV_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inv_conv) |-> $past(!tx_busy && rx_idle)); // R11

endmodule

bind sc_char_framer sc_char_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inv_conv  (inv_conv),
  .tx_ready  (tx_ready),
  .txd       (txd),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_ack    (rx_ack),
  .rx_overrun(rx_overrun),
  .tx_start  (tx_start),
  .tx_busy   (tx_busy),
  .rx_done   (rx_done),
  .rx_idle   (rx_idle)
);

// File: tb/sc_char_framer_test.sv
module sc_char_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int BD         = 8;
  localparam int GUARD      = 2;
  localparam int FRAME      = 10 + GUARD;

  logic       clk      = 1'b0;
  logic       rst_n    = 1'b0;
  logic       inv_conv = 1'b0;
  logic [7:0] bit_div  = 8'(BD);
  logic [7:0] tx_data  = '0;
  logic       tx_valid = 1'b0;
  logic       rx_ack   = 1'b0;
  logic       loop_en  = 1'b1;
  logic       rxd_drv  = 1'b1;
  logic       tx_ready, txd, rxd, rx_valid, rx_parity_err, rx_overrun;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;

  assign rxd = loop_en ? txd : rxd_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_char_framer #(.DIV_W(8), .GUARD_BITS(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .inv_conv(inv_conv), .bit_div(bit_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected line level of bit slot k, derived by counting.
  function automatic logic exp_bit(int k, logic [7:0] d, bit inv);
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= 8) return inv ? !d[8-k] : d[k-1];
    if (k == 9) begin
      for (int j = 0; j < 8; j++) ones += (inv ? !d[7-j] : d[j]) ? 1 : 0;
      return inv ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return 1'b1;
  endfunction

  task automatic do_ack();
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d, input bit inv, input bit chk_rx);
    int cur = 0;
    string tag;
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < FRAME; k++) begin
      int tgt = k * BD + BD / 2;
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      tx_valid = 1'b0;
      tag = (k == 0 || k > 9) ? "R4" : (inv ? "R3" : "R2");
      check(txd == exp_bit(k, d, inv), tag, txd, exp_bit(k, d, inv));
    end
    repeat (FRAME * BD - cur) @(negedge clk);
    check(tx_ready == 1'b0, "R4 ready low in last bit", tx_ready, 0);
    @(negedge clk);
    check(tx_ready == 1'b1, "R4 ready after frame", tx_ready, 1);
    if (chk_rx) begin
      check(rx_valid == 1'b1, "R6 valid", rx_valid, 1);
      check(rx_data == d, "R6 data", rx_data, d);
      check(rx_parity_err == 1'b0, "R7 good parity", rx_parity_err, 0);
      do_ack();
      check(rx_valid == 1'b0, "R9 ack clears", rx_valid, 0);
    end
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit inv, input bit flip);
    for (int k = 0; k < FRAME; k++) begin
      logic b = exp_bit(k, d, inv);
      if (k == 9 && flip) b = ~b;
      rxd_drv = b;
      repeat (BD) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    check(rx_parity_err == 1'b0, "R1 perr", rx_parity_err, 0);
    check(rx_overrun == 1'b0, "R1 overrun", rx_overrun, 0);

    // R5: first cycle after acceptance drives the start bit.
    tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(txd == 1'b0, "R5 start bit", txd, 0);
    check(tx_ready == 1'b0, "R5 taken", tx_ready, 0);
    while (!tx_ready) @(negedge clk);
    do_ack();

    // Exhaustive loopback in both conventions.
    for (int c = 0; c < 2; c++) begin
      inv_conv = c[0];
      @(negedge clk);
      for (int v = 0; v < 256; v++) send_tx(8'(v), c[0], 1'b1);
    end

    // R11: switch back while idle; the next character uses direct order.
    inv_conv = 1'b0;
    @(negedge clk);
    send_tx(8'h0F, 1'b0, 1'b0);
    check(rx_data == 8'h0F, "R11 after switch", rx_data, 8'h0F);
    do_ack();

    // R7: hand-driven frames with good and bad parity.
    loop_en = 1'b0;
    for (int c = 0; c < 2; c++) begin
      inv_conv = c[0];
      @(negedge clk);
      for (int f = 0; f < 2; f++) begin
        logic [7:0] d = f[0] ? 8'h3C : 8'hA5;
        drive_rx(d, c[0], 1'b1);
        check(rx_valid == 1'b1, "R7 valid on bad parity", rx_valid, 1);
        check(rx_data == d, "R7 data on bad parity", rx_data, d);
        check(rx_parity_err == 1'b1, "R7 perr set", rx_parity_err, 1);
        do_ack();
        drive_rx(d, c[0], 1'b0);
        check(rx_parity_err == 1'b0, "R7 perr clear", rx_parity_err, 0);
        check(rx_data == d, "R7 data good", rx_data, d);
        do_ack();
      end
    end

    // R8: a short low glitch is rejected.
    inv_conv = 1'b0;
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (2) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (3 * BD) @(negedge clk);
    check(rx_valid == 1'b0, "R8 glitch ignored", rx_valid, 0);
    drive_rx(8'hC3, 1'b0, 1'b0);
    check(rx_valid == 1'b1, "R8 ready after glitch", rx_valid, 1);
    check(rx_data == 8'hC3, "R8 data after glitch", rx_data, 8'hC3);
    do_ack();

    // R9 and R10: hold without acknowledge, then overrun.
    loop_en = 1'b1;
    @(negedge clk);
    send_tx(8'h11, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    check(rx_valid == 1'b1, "R9 held valid", rx_valid, 1);
    check(rx_data == 8'h11, "R9 held data", rx_data, 8'h11);
    check(rx_overrun == 1'b0, "R10 no overrun yet", rx_overrun, 0);
    send_tx(8'h22, 1'b0, 1'b0);
    check(rx_overrun == 1'b1, "R10 overrun set", rx_overrun, 1);
    check(rx_data == 8'h22, "R10 newest kept", rx_data, 8'h22);
    do_ack();
    check(rx_valid == 1'b0, "R10 valid cleared", rx_valid, 0);
    check(rx_overrun == 1'b0, "R10 overrun cleared", rx_overrun, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule